// File: doc/BRIEF.md
# Flash Command Interrupt Status Sequencer

This block holds the interrupt status word for one bank of a NAND flash controller. A command engine feeds it raw, single-cycle event strobes: the start of a command with its kind (erase, program or read), whether DMA is used, whether the target block is locked, and then page-transfer, failure, uncorrectable-ECC, pipeline-break, last-page and operation-done events. The block turns these into sticky status bits. For each command kind it raises them in a fixed order, one per clock, so software polling the word never sees a later bit before an earlier one. DMA completion always comes last.

Three bits sit outside that ordering. The watchdog bit, when it fires, wipes every other bit and discards queued events. The ready/busy-activity bit records a rising edge of the synchronised ready/busy pin. The reset-done bit records the end of a device reset. Software clears bits by writing ones. A per-bit enable mask gates the bits into a single registered interrupt line.

Top module: `flash_irq_seq`

## Requirements
- R1: After reset `status` is all zeros and `irq` is 0. Bit positions: 0 watchdog, 1 DMA done, 2 pipeline/copyback done, 3 locked block, 4 ready/busy rise, 5 reset done, 6 erase fail, 7 erase done, 8 pipeline error, 9 page transfer, 10 program fail, 11 program done, 12 load done, 13 uncorrectable ECC. `cmd_kind` encoding: 0 erase, 1 program, 2 read.
- R2: For an erase, a fail event sets bit 6 and a done event sets bit 7. When both are pending, bit 6 appears one clock before bit 7.
- R3: For a program, the pending bits appear one per clock in this order: locked block (set at start when `cmd_locked`), pipeline error, page transfer, program fail, pipeline/copyback done, program done, DMA done.
- R4: For a read, the pending bits appear one per clock in this order: pipeline error, page transfer, pipeline/copyback done, load done, uncorrectable ECC, DMA done. A read never sets the locked-block bit.
- R5: The DMA-done bit is queued by the done event only for a program or read whose start had `cmd_dma` high. It is never set for an erase.
- R6: One clock after `ev_wdog`, `status` holds only bit 0, and events queued before it are never raised.
- R7: A 0-to-1 change of `rb_pin` sets bit 4 on the third rising clock edge after the change, through a two-stage synchronizer. A 1-to-0 change sets nothing.
- R8: `ev_reset_done` sets bit 5 on the next edge, whatever the queue is doing.
- R9: With `clr_we` high, each 1 in `clr_mask` clears that status bit on the next edge. When a set and a clear hit the same bit in the same cycle, the bit ends up set.
- R10: `irq` is registered and equals the OR of (status AND `irq_en`), updating on the same edge as `status`.
- R11: During a read, `ev_fail` has no effect on any status bit.
- R12: A queued event reaches `status` on the second edge after its strobe. A `cmd_start` discards any still-queued events of the previous command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_start | input | 1 | Strobe: new command begins |
| cmd_kind | input | 2 | Command kind at start: 0 erase, 1 program, 2 read |
| cmd_dma | input | 1 | Command uses DMA (sampled at start) |
| cmd_locked | input | 1 | Target block is locked (sampled at start) |
| ev_page | input | 1 | Strobe: one page transfer finished |
| ev_fail | input | 1 | Strobe: erase or program failed |
| ev_ecc | input | 1 | Strobe: uncorrectable ECC on read |
| ev_pipe_break | input | 1 | Strobe: pipeline sequence interrupted |
| ev_last_page | input | 1 | Strobe: copyback or last pipeline page done |
| ev_done | input | 1 | Strobe: operation complete |
| ev_wdog | input | 1 | Strobe: watchdog timeout |
| ev_reset_done | input | 1 | Strobe: device reset finished |
| rb_pin | input | 1 | Asynchronous ready/busy pin |
| clr_we | input | 1 | Write-one-to-clear enable |
| clr_mask | input | 14 | Bits to clear |
| irq_en | input | 14 | Per-bit interrupt enable |
| status | output | 14 | Sticky status word |
| irq | output | 1 | Combined interrupt |

## Verification
Each result has its own latency. Queued command bits land two edges after their strobe and then one per edge. Watchdog, reset-done, clears and `irq` act one edge after their stimulus, and the ready/busy bit acts three edges after the pin changes. The bench drives every input on the falling edge and checks the status word after each single rising edge, comparing it against the cumulative value expected at that edge. An ordering slip or a missing or extra bit therefore shows up at the exact cycle it happens. After each sequence, further idle edges are checked to show that nothing late or unexpected appears.

// File: rtl/fis_pkg.sv
package fis_pkg;
  localparam int NSTAT  = 14;
  localparam int NCHAIN = 11;

  localparam logic [1:0] K_ERASE = 2'd0;
  localparam logic [1:0] K_PROG  = 2'd1;
  localparam logic [1:0] K_READ  = 2'd2;
  localparam logic [1:0] K_IDLE  = 2'd3;

  // status bit positions
  localparam int B_TMO       = 0;
  localparam int B_DMA       = 1;
  localparam int B_PIPE_DONE = 2;
  localparam int B_LOCK      = 3;
  localparam int B_RB        = 4;
  localparam int B_RST       = 5;
  localparam int B_ER_FAIL   = 6;
  localparam int B_ER_DONE   = 7;
  localparam int B_PIPE_ERR  = 8;
  localparam int B_PAGE      = 9;
  localparam int B_PG_FAIL   = 10;
  localparam int B_PG_DONE   = 11;
  localparam int B_LOAD      = 12;
  localparam int B_ECC       = 13;

  // queue slots, lowest index raised first; one order satisfies all kinds
  localparam int C_LOCK      = 0;
  localparam int C_ER_FAIL   = 1;
  localparam int C_ER_DONE   = 2;
  localparam int C_PIPE_ERR  = 3;
  localparam int C_PAGE      = 4;
  localparam int C_PG_FAIL   = 5;
  localparam int C_PIPE_DONE = 6;
  localparam int C_PG_DONE   = 7;
  localparam int C_LOAD      = 8;
  localparam int C_ECC       = 9;
  localparam int C_DMA       = 10;

  function automatic int slot_to_bit(input int c);
    case (c)
      C_LOCK:      return B_LOCK;
      C_ER_FAIL:   return B_ER_FAIL;
      C_ER_DONE:   return B_ER_DONE;
      C_PIPE_ERR:  return B_PIPE_ERR;
      C_PAGE:      return B_PAGE;
      C_PG_FAIL:   return B_PG_FAIL;
      C_PIPE_DONE: return B_PIPE_DONE;
      C_PG_DONE:   return B_PG_DONE;
      C_LOAD:      return B_LOAD;
      C_ECC:       return B_ECC;
      default:     return B_DMA;
    endcase
  endfunction
endpackage

// File: rtl/fis_rb_edge.sv
module fis_rb_edge #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic pin,
  output logic rise
);
  logic [STAGES-1:0] sync_q;
  logic              prev_q;

  always_ff @(posedge clk) begin
    if (rst) sync_q[0] <= 1'b0;
    else     sync_q[0] <= pin;
  end

  generate
    for (genvar i = 1; i < STAGES; i++) begin : g_stage
      always_ff @(posedge clk) begin
        if (rst) sync_q[i] <= 1'b0;
        else     sync_q[i] <= sync_q[i-1];
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) prev_q <= 1'b0;
    else     prev_q <= sync_q[STAGES-1];
  end

  assign rise = sync_q[STAGES-1] & ~prev_q;

  // R7: an edge yields exactly one pulse
  a_r7_single_pulse: assert property (@(posedge clk) disable iff (rst)
    rise |=> !rise);
endmodule

// File: rtl/fis_order_queue.sv
module fis_order_queue
  import fis_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             cmd_start,
  input  logic [1:0]       cmd_kind,
  input  logic             cmd_dma,
  input  logic             cmd_locked,
  input  logic             ev_page,
  input  logic             ev_fail,
  input  logic             ev_ecc,
  input  logic             ev_pipe_break,
  input  logic             ev_last_page,
  input  logic             ev_done,
  input  logic             wdog,
  output logic [NSTAT-1:0] raise
);
  logic [1:0]        kind_q;
  logic              dma_q;
  logic [NCHAIN-1:0] pend_q;
  logic [NCHAIN-1:0] new_ev;
  logic [NCHAIN-1:0] grant;

  always_comb begin
    new_ev = '0;
    if (!cmd_start) begin
      case (kind_q)
        K_ERASE: begin
          new_ev[C_ER_FAIL] = ev_fail;
          new_ev[C_ER_DONE] = ev_done;
        end
        K_PROG: begin
          new_ev[C_PIPE_ERR]  = ev_pipe_break;
          new_ev[C_PAGE]      = ev_page;
          new_ev[C_PG_FAIL]   = ev_fail;
          new_ev[C_PIPE_DONE] = ev_last_page;
          new_ev[C_PG_DONE]   = ev_done;
          new_ev[C_DMA]       = ev_done & dma_q;
        end
        K_READ: begin
          new_ev[C_PIPE_ERR]  = ev_pipe_break;
          new_ev[C_PAGE]      = ev_page;
          new_ev[C_PIPE_DONE] = ev_last_page;
          new_ev[C_LOAD]      = ev_done;
          new_ev[C_ECC]       = ev_ecc;
          new_ev[C_DMA]       = ev_done & dma_q;
        end
        default: new_ev = '0;
      endcase
    end
  end

  // isolate the earliest pending slot
  assign grant = pend_q & (~pend_q + 1'b1);

  always_ff @(posedge clk) begin
    if (rst) begin
      kind_q <= K_IDLE;
      dma_q  <= 1'b0;
      pend_q <= '0;
    end else if (wdog) begin
      pend_q <= '0;
    end else if (cmd_start) begin
      kind_q <= cmd_kind;
      dma_q  <= cmd_dma;
      pend_q <= '0;
      pend_q[C_LOCK] <= cmd_locked & (cmd_kind == K_PROG || cmd_kind == K_ERASE);
    end else begin
      pend_q <= (pend_q & ~grant) | new_ev;
    end
  end

  always_comb begin
    raise = '0;
    for (int c = 0; c < NCHAIN; c++) begin
      raise[slot_to_bit(c)] = raise[slot_to_bit(c)] | grant[c];
    end
  end

  // R5: DMA completion only for a DMA-enabled program or read
  a_r5_dma_gate: assert property (@(posedge clk) disable iff (rst)
    raise[B_DMA] |-> (dma_q && kind_q != K_ERASE));
endmodule

// File: rtl/fis_status_reg.sv
module fis_status_reg
  import fis_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic [NSTAT-1:0] raise,
  input  logic             wdog,
  input  logic             rb_rise,
  input  logic             reset_done,
  input  logic             clr_we,
  input  logic [NSTAT-1:0] clr_mask,
  input  logic [NSTAT-1:0] irq_en,
  output logic [NSTAT-1:0] status,
  output logic             irq
);
  localparam logic [NSTAT-1:0] TMO_ONLY = NSTAT'(1) << B_TMO;

  logic [NSTAT-1:0] set_v;
  logic [NSTAT-1:0] clr_v;
  logic [NSTAT-1:0] status_d;

  always_comb begin
    set_v = raise;
    set_v[B_RB]  = set_v[B_RB]  | rb_rise;
    set_v[B_RST] = set_v[B_RST] | reset_done;
    clr_v = clr_we ? clr_mask : '0;
    if (wdog) status_d = TMO_ONLY;
    else      status_d = (status & ~clr_v) | set_v;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      status <= '0;
      irq    <= 1'b0;
    end else begin
      status <= status_d;
      irq    <= |(status_d & irq_en);
    end
  end

  // R6: watchdog leaves only its own bit
  a_r6_tmo_only: assert property (@(posedge clk) disable iff (rst)
    wdog |=> (status == TMO_ONLY));
  // R3: the queue never offers two bits at once
  a_r3_one_raise: assert property (@(posedge clk) disable iff (rst)
    $onehot0(raise));
  // R9: a raised bit is present next cycle even under a clear
  a_r9_set_wins: assert property (@(posedge clk) disable iff (rst)
    (!wdog && |raise) |=> ((status & $past(raise)) == $past(raise)));
  // R10: interrupt tracks the enabled status bits
  a_r10_irq: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (irq == |(status & $past(irq_en))));
endmodule

// File: rtl/flash_irq_seq.sv
module flash_irq_seq
  import fis_pkg::*;
#(
  parameter int RB_SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cmd_start,
  input  logic [1:0]       cmd_kind,
  input  logic             cmd_dma,
  input  logic             cmd_locked,
  input  logic             ev_page,
  input  logic             ev_fail,
  input  logic             ev_ecc,
  input  logic             ev_pipe_break,
  input  logic             ev_last_page,
  input  logic             ev_done,
  input  logic             ev_wdog,
  input  logic             ev_reset_done,
  input  logic             rb_pin,
  input  logic             clr_we,
  input  logic [NSTAT-1:0] clr_mask,
  input  logic [NSTAT-1:0] irq_en,
  output logic [NSTAT-1:0] status,
  output logic             irq
);
  logic             rb_rise;
  logic [NSTAT-1:0] raise;

  fis_rb_edge #(.STAGES(RB_SYNC_STAGES)) u_rb (
    .clk  (clk),
    .rst  (rst),
    .pin  (rb_pin),
    .rise (rb_rise)
  );

  fis_order_queue u_queue (
    .clk           (clk),
    .rst           (rst),
    .cmd_start     (cmd_start),
    .cmd_kind      (cmd_kind),
    .cmd_dma       (cmd_dma),
    .cmd_locked    (cmd_locked),
    .ev_page       (ev_page),
    .ev_fail       (ev_fail),
    .ev_ecc        (ev_ecc),
    .ev_pipe_break (ev_pipe_break),
    .ev_last_page  (ev_last_page),
    .ev_done       (ev_done),
    .wdog          (ev_wdog),
    .raise         (raise)
  );

  fis_status_reg u_stat (
    .clk        (clk),
    .rst        (rst),
    .raise      (raise),
    .wdog       (ev_wdog),
    .rb_rise    (rb_rise),
    .reset_done (ev_reset_done),
    .clr_we     (clr_we),
    .clr_mask   (clr_mask),
    .irq_en     (irq_en),
    .status     (status),
    .irq        (irq)
  );
endmodule

// File: tb/flash_irq_seq_tb.sv
`timescale 1ns/1ps
module flash_irq_seq_tb;
  import fis_pkg::*;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cmd_start = 0, cmd_dma = 0, cmd_locked = 0;
  logic [1:0] cmd_kind = 0;
  logic ev_page = 0, ev_fail = 0, ev_ecc = 0, ev_pipe_break = 0;
  logic ev_last_page = 0, ev_done = 0, ev_wdog = 0, ev_reset_done = 0;
  logic rb_pin = 0, clr_we = 0;
  logic [NSTAT-1:0] clr_mask = '0, irq_en = '0;
  logic [NSTAT-1:0] status;
  logic irq;

  int errors = 0;
  int checks = 0;

  always #4 clk = ~clk;

  flash_irq_seq u_dut (
    .clk(clk), .rst(rst), .cmd_start(cmd_start), .cmd_kind(cmd_kind),
    .cmd_dma(cmd_dma), .cmd_locked(cmd_locked), .ev_page(ev_page),
    .ev_fail(ev_fail), .ev_ecc(ev_ecc), .ev_pipe_break(ev_pipe_break),
    .ev_last_page(ev_last_page), .ev_done(ev_done), .ev_wdog(ev_wdog),
    .ev_reset_done(ev_reset_done), .rb_pin(rb_pin), .clr_we(clr_we),
    .clr_mask(clr_mask), .irq_en(irq_en), .status(status), .irq(irq)
  );

  function automatic logic [NSTAT-1:0] bm(input int b);
    return NSTAT'(1) << b;
  endfunction

  task automatic chk(input logic [NSTAT-1:0] act, input logic [NSTAT-1:0] exp,
                     input string req);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic clear_all();
    clr_we = 1; clr_mask = '1;
    tick();
    clr_we = 0; clr_mask = '0;
    repeat (3) tick();
  endtask

  task automatic start(input logic [1:0] k, input logic dma, input logic lk);
    cmd_start = 1; cmd_kind = k; cmd_dma = dma; cmd_locked = lk;
    tick();
    cmd_start = 0; cmd_dma = 0; cmd_locked = 0;
  endtask

  task automatic drop_events();
    ev_page = 0; ev_fail = 0; ev_ecc = 0; ev_pipe_break = 0;
    ev_last_page = 0; ev_done = 0;
  endtask

  task automatic t_reset();
    chk(status, '0, "R1 status after reset");
    chk({13'd0, irq}, '0, "R1 irq after reset");
  endtask

  task automatic t_program();
    logic [NSTAT-1:0] acc;
    int seq [6] = '{B_PIPE_ERR, B_PAGE, B_PG_FAIL, B_PIPE_DONE, B_PG_DONE, B_DMA};
    clear_all();
    start(K_PROG, 1, 1);
    chk(status, '0, "R12 nothing before queue drains");
    ev_pipe_break = 1; ev_page = 1; ev_fail = 1; ev_last_page = 1; ev_done = 1;
    tick();
    drop_events();
    acc = bm(B_LOCK);
    chk(status, acc, "R3 locked block first");
    for (int i = 0; i < 6; i++) begin
      tick();
      acc |= bm(seq[i]);
      chk(status, acc, "R3 program order step");
    end
    tick();
    chk(status, acc, "R3 nothing after DMA done");
  endtask

  task automatic t_read();
    logic [NSTAT-1:0] acc;
    int seq [6] = '{B_PIPE_ERR, B_PAGE, B_PIPE_DONE, B_LOAD, B_ECC, B_DMA};
    clear_all();
    start(K_READ, 1, 1);
    ev_pipe_break = 1; ev_page = 1; ev_last_page = 1; ev_done = 1; ev_ecc = 1;
    tick();
    drop_events();
    chk(status, '0, "R4 read sets no locked bit");
    acc = '0;
    for (int i = 0; i < 6; i++) begin
      tick();
      acc |= bm(seq[i]);
      chk(status, acc, "R4 read order step");
    end
  endtask

  task automatic t_erase();
    clear_all();
    start(K_ERASE, 1, 0);
    ev_fail = 1; ev_done = 1;
    tick();
    drop_events();
    chk(status, '0, "R12 two-edge latency");
    tick();
    chk(status, bm(B_ER_FAIL), "R2 erase fail first");
    tick();
    chk(status, bm(B_ER_FAIL) | bm(B_ER_DONE), "R2 erase done second");
    tick();
    chk(status, bm(B_ER_FAIL) | bm(B_ER_DONE), "R5 no DMA bit for erase");
  endtask

  task automatic t_no_dma();
    clear_all();
    start(K_PROG, 0, 0);
    ev_done = 1;
    tick();
    drop_events();
    tick();
    chk(status, bm(B_PG_DONE), "R5 program done without DMA");
    tick();
    chk(status, bm(B_PG_DONE), "R5 DMA bit absent when not enabled");
  endtask

  task automatic t_read_fail();
    clear_all();
    start(K_READ, 0, 0);
    ev_fail = 1;
    tick();
    drop_events();
    repeat (2) tick();
    chk(status, '0, "R11 fail ignored in read");
  endtask

  task automatic t_restart();
    clear_all();
    start(K_PROG, 0, 0);
    ev_page = 1; ev_done = 1;
    tick();
    drop_events();
    start(K_ERASE, 0, 0);
    chk(status, bm(B_PAGE), "R12 first queued bit raised");
    repeat (2) tick();
    chk(status, bm(B_PAGE), "R12 restart discards queue");
  endtask

  task automatic t_watchdog();
    clear_all();
    ev_reset_done = 1;
    tick();
    ev_reset_done = 0;
    chk(status, bm(B_RST), "R8 reset done next edge");
    start(K_PROG, 1, 0);
    ev_page = 1; ev_done = 1;
    tick();
    drop_events();
    tick();
    chk(status, bm(B_RST) | bm(B_PAGE), "R8 reset bit kept beside queue");
    ev_wdog = 1;
    tick();
    ev_wdog = 0;
    chk(status, bm(B_TMO), "R6 watchdog clears others");
    repeat (3) tick();
    chk(status, bm(B_TMO), "R6 queued events discarded");
  endtask

  task automatic t_clear_irq();
    // status holds the watchdog bit from the previous task
    irq_en = bm(B_RST);
    tick();
    chk({13'd0, irq}, '0, "R10 irq low, enabled bit clear");
    clr_we = 1; clr_mask = bm(B_TMO) | bm(B_RST); ev_reset_done = 1;
    tick();
    clr_we = 0; clr_mask = '0; ev_reset_done = 0;
    chk(status, bm(B_RST), "R9 clear works and set wins");
    chk({13'd0, irq}, 14'd1, "R10 irq same edge as status");
    irq_en = bm(B_TMO);
    tick();
    chk({13'd0, irq}, '0, "R10 irq follows mask");
    irq_en = '0;
  endtask

  task automatic t_rb();
    clear_all();
    rb_pin = 1;
    tick();
    tick();
    chk(status, '0, "R7 not yet after two edges");
    tick();
    chk(status, bm(B_RB), "R7 rise on third edge");
    clr_we = 1; clr_mask = bm(B_RB);
    tick();
    clr_we = 0; clr_mask = '0;
    rb_pin = 0;
    repeat (5) tick();
    chk(status, '0, "R7 falling edge ignored");
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) tick();
    rst = 0;
    tick();
    t_reset();
    t_program();
    t_read();
    t_erase();
    t_no_dma();
    t_read_fail();
    t_restart();
    t_watchdog();
    t_clear_irq();
    t_rb();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule